// File: doc/BRIEF.md
# PHY Parallel Register Write Engine

This block programs a fixed initialisation word into one control register per lane on two PHY instances over a parallel address/data register port. Each write uses a four-phase request/acknowledge handshake. A single-cycle `start` pulse first drives the select line of every PHY high. The engine then waits a settle interval before it issues eight writes, one at a time: lanes 0 to 3 of PHY 0 first, then lanes 0 to 3 of PHY 1.

The address and data buses are shared by both PHYs. Each PHY has its own write-enable and acknowledge line, and `phyIdx` shows which PHY the current write targets. For every write, the engine presents the address and data and raises the enable. It waits for acknowledge to rise, drops the enable, and waits for acknowledge to fall. Each of those two waits has its own cycle-count limit. When a limit expires, the engine sets a sticky warning flag and carries on with the sequence. When the sequence ends, `done` stays high until the next start.

Top module: `phy_regwr_engine`

## Requirements
- R1: After reset, `phySelect`, `phyWrEn`, `done` and `timeoutWarn` are all 0.
- R2: An accepted start sets every bit of `phySelect` to 1, and the bits stay 1. The first enable rises exactly SETTLE_CYCLES+2 cycles after the cycle in which `start` is high. A `phyWrEn` bit is never high while its `phySelect` bit is 0.
- R3: `regWrData` equals INIT_WORD (default 0x0E21, bits 0, 5, 9, 10 and 11 set) whenever a write is in progress. `regAddr` and `regWrData` are valid one cycle before the enable rises and stay stable while it is high.
- R4: The write to lane n uses address LANE_BASE + LANE_STRIDE × n (defaults 0x1008 and 0x100).
- R5: Writes go in the order PHY 0 lanes 0 to 3, then PHY 1 lanes 0 to 3. `phyIdx` gives the target PHY, and only `phyWrEn[phyIdx]` is driven, so at most one enable bit is high.
- R6: The enable drops in the cycle after the target PHY's acknowledge is sampled high. The next write's setup cycle starts only after acknowledge is sampled low.
- R7: If acknowledge is not seen high within TIMEOUT_CYCLES cycles of the enable rising, the enable drops, `timeoutWarn` is set and the sequence continues.
- R8: If acknowledge is still high TIMEOUT_CYCLES cycles after the enable falls, `timeoutWarn` is set and the engine moves to the next write anyway.
- R9: `timeoutWarn` stays set until the next accepted start, which clears it.
- R10: `done` goes high after the eighth write completes and holds until the next accepted start clears it. No enable is high while `done` is high.
- R11: A start pulse that arrives while a sequence is in progress is ignored. Acknowledge from the PHY that is not the target has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; accepted only when idle or done |
| phyAck | input | NUM_PHYS | Per-PHY handshake acknowledge |
| phySelect | output | NUM_PHYS | Per-PHY register-port select line |
| phyIdx | output | clog2(NUM_PHYS) | Target PHY of the current write |
| regAddr | output | ADDR_W | Shared register address |
| regWrData | output | DATA_W | Shared write data |
| phyWrEn | output | NUM_PHYS | Per-PHY write enable |
| done | output | 1 | Sequence complete, held until next start |
| timeoutWarn | output | 1 | Sticky handshake timeout warning |

## Verification
The bench builds the block with two PHYs, four lanes and the default settle of 10 cycles. It reduces TIMEOUT_CYCLES to 16, so both the rising-edge timeout and the falling-edge timeout occur within a few dozen cycles instead of hundreds of thousands. With that short limit, a single run can include an acknowledge that never rises, an acknowledge held high onto the idle PHY, and a redundant start in the middle of the sequence. The sticky warning can then be seen being cleared by the following run.

// File: rtl/phywr_pkg.sv
package phywr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_SETUP,
    ST_WAIT_HI,
    ST_WAIT_LO,
    ST_DONE
  } engState_e;

  typedef struct packed {
    logic beginRun;
    logic nextWrite;
    logic flagTimeout;
  } engStrobe_t;

endpackage

// File: rtl/phywr_ctrl.sv
module phywr_ctrl
  import phywr_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES  = 10,
  parameter int unsigned TIMEOUT_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       ackSel,
  input  logic       lastWrite,
  output engStrobe_t strobe,
  output logic       wrActive,
  output logic       runDone
);

  localparam int unsigned CNT_MAX = (SETTLE_CYCLES > TIMEOUT_CYCLES) ? SETTLE_CYCLES : TIMEOUT_CYCLES;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] TMO_LAST    = CNT_W'(TIMEOUT_CYCLES - 1);

  engState_e       state, nxtState;
  logic [CNT_W-1:0] cnt;
  logic            cntClr, cntInc;

  always_comb begin
    nxtState = state;
    cntClr   = 1'b0;
    cntInc   = 1'b0;
    strobe   = '0;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          nxtState        = ST_SETTLE;
          strobe.beginRun = 1'b1;
          cntClr          = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (cnt == SETTLE_LAST) begin
          nxtState = ST_SETUP;
          cntClr   = 1'b1;
        end else begin
          cntInc = 1'b1;
        end
      end
      ST_SETUP: begin
        nxtState = ST_WAIT_HI;
        cntClr   = 1'b1;
      end
      ST_WAIT_HI: begin
        if (ackSel) begin
          nxtState = ST_WAIT_LO;
          cntClr   = 1'b1;
        end else if (cnt == TMO_LAST) begin
          nxtState           = ST_WAIT_LO;
          cntClr             = 1'b1;
          strobe.flagTimeout = 1'b1;
        end else begin
          cntInc = 1'b1;
        end
      end
      ST_WAIT_LO: begin
        if (!ackSel || cnt == TMO_LAST) begin
          cntClr             = 1'b1;
          strobe.flagTimeout = ackSel;
          if (lastWrite) begin
            nxtState = ST_DONE;
          end else begin
            nxtState         = ST_SETUP;
            strobe.nextWrite = 1'b1;
          end
        end else begin
          cntInc = 1'b1;
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxtState;
      if (cntClr)      cnt <= '0;
      else if (cntInc) cnt <= cnt + 1'b1;
    end
  end

  assign wrActive = (state == ST_WAIT_HI);
  assign runDone  = (state == ST_DONE);

  // R6: a write ends only once the enable phase has finished
  p_write_after_enable_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.nextWrite |-> !wrActive);

  // R11: a start pulse during a run never re-enters the settle phase
  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rstN)
    (start && (state == ST_WAIT_HI || state == ST_WAIT_LO)) |=> state != ST_SETTLE);

endmodule

// File: rtl/phywr_datapath.sv
module phywr_datapath
  import phywr_pkg::*;
#(
  parameter int unsigned NUM_PHYS    = 2,
  parameter int unsigned NUM_LANES   = 4,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned LANE_BASE   = 32'h1008,
  parameter int unsigned LANE_STRIDE = 32'h100,
  parameter int unsigned INIT_WORD   = 32'h0E21
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  engStrobe_t                  strobe,
  input  logic                        wrActive,
  input  logic                        runDone,
  input  logic [NUM_PHYS-1:0]         phyAck,
  output logic                        ackSel,
  output logic                        lastWrite,
  output logic [NUM_PHYS-1:0]         phySelect,
  output logic [$clog2(NUM_PHYS)-1:0] phyIdx,
  output logic [ADDR_W-1:0]           regAddr,
  output logic [DATA_W-1:0]           regWrData,
  output logic [NUM_PHYS-1:0]         phyWrEn,
  output logic                        done,
  output logic                        timeoutWarn
);

  localparam int unsigned PHY_W  = $clog2(NUM_PHYS);
  localparam int unsigned LANE_W = $clog2(NUM_LANES);
  localparam int unsigned IDX_W  = PHY_W + LANE_W;

  logic [IDX_W-1:0]  wrIdx;
  logic [LANE_W-1:0] laneIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx       <= '0;
      phySelect   <= '0;
      timeoutWarn <= 1'b0;
    end else begin
      if (strobe.beginRun) begin
        wrIdx       <= '0;
        phySelect   <= '1;
        timeoutWarn <= 1'b0;
      end else begin
        if (strobe.nextWrite)   wrIdx       <= wrIdx + 1'b1;
        if (strobe.flagTimeout) timeoutWarn <= 1'b1;
      end
    end
  end

  assign laneIdx   = wrIdx[LANE_W-1:0];
  assign phyIdx    = wrIdx[IDX_W-1:LANE_W];
  assign lastWrite = (wrIdx == '1);
  assign regAddr   = ADDR_W'(LANE_BASE + LANE_STRIDE * 32'(laneIdx));
  assign regWrData = DATA_W'(INIT_WORD);
  assign ackSel    = phyAck[phyIdx];
  assign done      = runDone;

  for (genvar p = 0; p < NUM_PHYS; p++) begin : g_phy_en
    assign phyWrEn[p] = wrActive && (phyIdx == PHY_W'(p));
  end

  p_onehot_wren_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(phyWrEn));

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (phyWrEn != '0) |-> ($stable(regAddr) && $stable(regWrData)));

  p_wren_selected_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phyWrEn & ~phySelect) == '0);

  p_warn_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutWarn && !strobe.beginRun) |=> timeoutWarn);

  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (phyWrEn == '0));

endmodule

// File: rtl/phy_regwr_engine.sv
module phy_regwr_engine
  import phywr_pkg::*;
#(
  parameter int unsigned NUM_PHYS       = 2,
  parameter int unsigned NUM_LANES      = 4,
  parameter int unsigned ADDR_W         = 16,
  parameter int unsigned DATA_W         = 16,
  parameter int unsigned LANE_BASE      = 32'h1008,
  parameter int unsigned LANE_STRIDE    = 32'h100,
  parameter int unsigned INIT_WORD      = 32'h0E21,
  parameter int unsigned SETTLE_CYCLES  = 10,
  parameter int unsigned TIMEOUT_CYCLES = 500000
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [NUM_PHYS-1:0]         phyAck,
  output logic [NUM_PHYS-1:0]         phySelect,
  output logic [$clog2(NUM_PHYS)-1:0] phyIdx,
  output logic [ADDR_W-1:0]           regAddr,
  output logic [DATA_W-1:0]           regWrData,
  output logic [NUM_PHYS-1:0]         phyWrEn,
  output logic                        done,
  output logic                        timeoutWarn
);

  engStrobe_t strobe;
  logic       wrActive, runDone, ackSel, lastWrite;

  phywr_ctrl #(
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .ackSel   (ackSel),
    .lastWrite(lastWrite),
    .strobe   (strobe),
    .wrActive (wrActive),
    .runDone  (runDone)
  );

  phywr_datapath #(
    .NUM_PHYS   (NUM_PHYS),
    .NUM_LANES  (NUM_LANES),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .LANE_BASE  (LANE_BASE),
    .LANE_STRIDE(LANE_STRIDE),
    .INIT_WORD  (INIT_WORD)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrActive   (wrActive),
    .runDone    (runDone),
    .phyAck     (phyAck),
    .ackSel     (ackSel),
    .lastWrite  (lastWrite),
    .phySelect  (phySelect),
    .phyIdx     (phyIdx),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .phyWrEn    (phyWrEn),
    .done       (done),
    .timeoutWarn(timeoutWarn)
  );

endmodule

// File: tb/phy_regwr_engine_tb.sv
module phy_regwr_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;
  localparam int NL = 4;
  localparam int NW = NP * NL;
  localparam int SETTLE = 10;
  localparam int TMO = 16;
  localparam int M_NORMAL = 0, M_STUCK_LO = 1, M_STUCK_HI = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [NP-1:0] phyAck = '0;
  logic [NP-1:0] phySelect;
  logic [0:0]    phyIdx;
  logic [15:0]   regAddr, regWrData;
  logic [NP-1:0] phyWrEn;
  logic          done, timeoutWarn;

  phy_regwr_engine #(
    .NUM_PHYS(NP), .NUM_LANES(NL), .SETTLE_CYCLES(SETTLE), .TIMEOUT_CYCLES(TMO)
  ) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .phyAck(phyAck),
    .phySelect(phySelect), .phyIdx(phyIdx), .regAddr(regAddr),
    .regWrData(regWrData), .phyWrEn(phyWrEn), .done(done),
    .timeoutWarn(timeoutWarn)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0, mismatched = 0;

  // reference model
  int mPhase = 0, mCnt = 0, mIdx = 0;
  bit mWarn = 0, mSel = 0;
  // responder and stimulus
  int riseDly = 2, fallDly = 3, rCnt = 0, wrNum = -1;
  int mode [NW];
  bit startReq = 0;
  int cycle = 0, startCycle = 0, firstRise = -1;
  logic [NP-1:0] prevWrEn = '0;
  int logAddr[$];
  int logPhy[$];

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cycle);
    end
  endtask

  task automatic compareAll();
    int ph = mIdx / NL;
    int ln = mIdx % NL;
    logic [NP-1:0] expEn = (mPhase == 3) ? NP'(1 << ph) : '0;
    chk("R2", "phySelect", 32'(phySelect), mSel ? 32'(2**NP - 1) : 32'd0);
    chk("R6", "phyWrEn", 32'(phyWrEn), 32'(expEn));
    chk("R10", "done", 32'(done), 32'(mPhase == 5));
    chk("R9", "timeoutWarn", 32'(timeoutWarn), 32'(mWarn));
    if (mPhase >= 2 && mPhase <= 4) begin
      chk("R5", "phyIdx", 32'(phyIdx), 32'(ph));
      chk("R4", "regAddr", 32'(regAddr), 32'h1008 + 32'h100 * 32'(ln));
      chk("R3", "regWrData", 32'(regWrData), 32'h0E21);
    end
  endtask

  task automatic respond();
    int p = int'(phyIdx);
    int cm = (wrNum >= 0 && wrNum < NW) ? mode[wrNum] : M_NORMAL;
    if (phyWrEn != '0) begin
      if (!phyAck[p]) begin
        rCnt++;
        if (cm != M_STUCK_LO && rCnt >= riseDly) begin phyAck[p] = 1'b1; rCnt = 0; end
      end else rCnt = 0;
    end else if (phyAck[p]) begin
      rCnt++;
      if (cm != M_STUCK_HI && rCnt >= fallDly) begin phyAck[p] = 1'b0; rCnt = 0; end
    end else rCnt = 0;
  endtask

  task automatic advanceModel(bit st, bit a);
    case (mPhase)
      0, 5: if (st) begin mPhase = 1; mCnt = 0; mIdx = 0; mWarn = 0; mSel = 1; end
      1: if (mCnt == SETTLE - 1) begin mPhase = 2; mCnt = 0; end else mCnt++;
      2: begin mPhase = 3; mCnt = 0; end
      3: if (a) begin mPhase = 4; mCnt = 0; end
         else if (mCnt == TMO - 1) begin mPhase = 4; mCnt = 0; mWarn = 1; end
         else mCnt++;
      4: if (!a || mCnt == TMO - 1) begin
           if (a) mWarn = 1;
           mCnt = 0;
           if (mIdx == NW - 1) mPhase = 5;
           else begin mIdx++; mPhase = 2; end
         end else mCnt++;
      default: mPhase = 0;
    endcase
  endtask

  // per-cycle engine: compare, respond, drive inputs, advance model
  initial begin
    forever begin
      @(negedge clk);
      cycle++;
      if (!rstN) begin
        mPhase = 0; mCnt = 0; mIdx = 0; mWarn = 0; mSel = 0;
      end else begin
        compareAll();
        if (phyWrEn != '0 && prevWrEn == '0) begin
          wrNum++;
          if (firstRise < 0) firstRise = cycle;
          logAddr.push_back(int'(regAddr));
          logPhy.push_back(int'(phyIdx));
        end
        prevWrEn = phyWrEn;
        respond();
        start = startReq;
        if (startReq) begin
          startReq = 0;
          startCycle = cycle;
          if (mPhase == 0 || mPhase == 5) begin
            phyAck = '0; rCnt = 0; wrNum = -1; firstRise = -1;
            logAddr.delete(); logPhy.delete();
          end
        end
        advanceModel(start, phyAck[mIdx / NL]);
      end
    end
  end

  task automatic requestStart();
    @(posedge clk);
    #1 startReq = 1;
    repeat (3) @(posedge clk);
  endtask

  task automatic waitDone();
    while (!done) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (CLK_PERIOD * 2000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) mode[i] = M_NORMAL;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "phySelect", 32'(phySelect), 0);
    chk("R1", "phyWrEn", 32'(phyWrEn), 0);
    chk("R1", "done", 32'(done), 0);
    chk("R1", "timeoutWarn", 32'(timeoutWarn), 0);
    @(posedge clk); #1 rstN = 1;
    repeat (4) @(posedge clk);

    // run 1: clean handshakes
    riseDly = 2; fallDly = 3;
    requestStart();
    waitDone();
    chk("R2", "settle cycles to first enable", 32'(firstRise - startCycle), 32'(SETTLE + 2));
    chk("R5", "write count", 32'(logAddr.size()), 32'(NW));
    for (int i = 0; i < logAddr.size(); i++) begin
      chk("R4", "logged address", 32'(logAddr[i]), 32'h1008 + 32'h100 * 32'(i % NL));
      chk("R5", "logged phy", 32'(logPhy[i]), 32'(i / NL));
    end
    chk("R10", "done after run", 32'(done), 1);
    chk("R7", "no warn on clean run", 32'(timeoutWarn), 0);

    // run 2: stuck-low on write 1, stuck-high on write 3, mid-run start
    riseDly = 1; fallDly = 1;
    mode[1] = M_STUCK_LO;
    mode[3] = M_STUCK_HI;
    requestStart();
    repeat (40) @(posedge clk);
    requestStart();          // R11: ignored while busy
    waitDone();
    chk("R11", "writes despite mid-run start", 32'(logAddr.size()), 32'(NW));
    chk("R7", "warn after rise timeout", 32'(timeoutWarn), 1);
    chk("R8", "all writes done after fall timeout", 32'(done), 1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R9", "warn held while done", 32'(timeoutWarn), 1);

    // run 3: start clears warn
    mode[1] = M_NORMAL; mode[3] = M_NORMAL;
    @(posedge clk); #1 startReq = 1;
    @(posedge clk); @(negedge clk);
    chk("R9", "warn cleared by start", 32'(timeoutWarn), 0);
    chk("R10", "done cleared by start", 32'(done), 0);
    repeat (2) @(posedge clk);
    waitDone();
    chk("R9", "warn clear after clean run", 32'(timeoutWarn), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule